// File: doc/BRIEF.md
# Run-time programmable serial CRC engine

This block is a bit-serial CRC calculator whose generator polynomial is chosen while the chip runs. A 4-bit length code selects a generator of 1 to 16 bits, and a tap mask selects the lower-order terms. Each strobe on the shift input folds one message bit into the remainder register. Message elements are fed most significant bit first. Strobes need not be back to back, so the engine can pause between bits.

Software seeds the remainder through a direct load port. The seed is usually zero at the start of a message, or a partial remainder saved from an earlier run. The load is accepted only while the engine is stopped. The remainder is visible on the result port at all times. To obtain the final remainder, the caller appends as many zero bits as the generator is long.

Top module: `prog_crc_core`

## Requirements
- R1: After reset the result port reads 0x0000.
- R2: The generator length is the length code plus one (code 0 gives 1 bit, code 15 gives 16 bits). Result bits at or above that length always read zero.
- R3: The remainder changes on a rising clock edge only when `shiftEn` is 1 and `engineRun` is 1. Otherwise it holds, apart from the load in R7.
- R4: On each accepted shift, with L the generator length, the feedback bit is remainder bit L-1. The remainder moves one place toward the most significant bit and `dataBit` enters bit 0. If the feedback bit was 1, the tap mask with bit 0 forced to 1 (the x0 term) is then XORed in. The result is truncated to L bits.
- R5: Bit 0 of `tapMask` has no effect: tap values 0x1020 and 0x1021 give identical remainders.
- R6: Tap mask bits at or above the generator length have no effect on the remainder.
- R7: When `seedWr` is 1 and `engineRun` is 0, the next rising edge loads `seedVal` truncated to the generator length.
- R8: A `seedWr` while `engineRun` is 1 is ignored. A shift strobe in the same cycle is still applied as in R4.
- R9: With length code 15, tap mask 0x1020, seed 0 and message bytes fed MSB first, the ASCII string "123456789" followed by 16 zero bits yields 0x31C3.
- R10: Idle cycles inserted between shift strobes do not change the final remainder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| lenCode | input | 4 | Generator length minus one |
| tapMask | input | 16 | Polynomial terms x15..x1 (bit 0 ignored) |
| engineRun | input | 1 | Engine running; enables shifting, blocks loads |
| shiftEn | input | 1 | One-bit advance strobe |
| dataBit | input | 1 | Message bit for this strobe |
| seedWr | input | 1 | Load request for the remainder register |
| seedVal | input | 16 | Value to load |
| crcOut | output | 16 | Current remainder, masked to the generator length |

## Verification
The seed load and the shift strobe can both be requested in the same cycle. The bench raises `seedWr` with a seed value together with `shiftEn` while the engine runs. It then expects exactly the one-bit advance of R4 and no trace of the seed. It also asserts `seedWr` on a running engine with no strobe and expects the remainder to hold. A behavioural bit-by-bit model is compared with the result port every cycle. Fixed known remainders confirm the generator setup, and further runs show that tap bit 0, out-of-range taps and idle gaps leave the result unchanged.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;
  parameter int unsigned CRC_MAX_W = 16;

  typedef struct packed {
    logic doShift;
    logic doLoad;
  } crcStrobes_t;
endpackage

// File: rtl/crc_ctrl.sv
module crc_ctrl
  import crc_eng_pkg::*;
(
  input  logic        engineRun,
  input  logic        shiftEn,
  input  logic        seedWr,
  output crcStrobes_t strb
);
  // R3: shifting needs a running engine; R7/R8: loading needs a stopped one
  always_comb begin
    strb.doShift = engineRun & shiftEn;
    strb.doLoad  = ~engineRun & seedWr;
  end
endmodule

// File: rtl/crc_datapath.sv
module crc_datapath
  import crc_eng_pkg::*;
#(
  parameter int unsigned MAX_W = CRC_MAX_W,
  localparam int unsigned LW   = $clog2(MAX_W)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  crcStrobes_t      strb,
  input  logic [LW-1:0]    lenCode,
  input  logic [MAX_W-1:0] tapMask,
  input  logic             dataBit,
  input  logic [MAX_W-1:0] seedVal,
  output logic [MAX_W-1:0] crcOut
);
  logic [MAX_W-1:0] remReg;
  logic [MAX_W-1:0] lenMask;
  logic [MAX_W-1:0] tapEff;
  logic [MAX_W-1:0] stepVal;
  logic             fbBit;

  // thermometer mask: bit i kept when i < length
  always_comb begin
    for (int i = 0; i < MAX_W; i++) lenMask[i] = (i <= int'(lenCode));
  end

  assign fbBit   = remReg[lenCode];
  assign tapEff  = {tapMask[MAX_W-1:1], 1'b1} & lenMask;
  assign stepVal = ({remReg[MAX_W-2:0], dataBit} ^ (fbBit ? tapEff : '0)) & lenMask;
  assign crcOut  = remReg & lenMask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remReg <= '0;
    else if (strb.doLoad)    remReg <= seedVal & lenMask;
    else if (strb.doShift)   remReg <= stepVal;
  end

  // R3: no strobe, no change
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.doLoad && !strb.doShift) |=> (remReg == $past(remReg)));

  // R7: load lands truncated to the length in force at the load
  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.doLoad |=> (remReg == ($past(seedVal) & $past(lenMask))));

  // R4: new bit 0 is the data bit combined with the x0 feedback term
  p_shift_lsb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.doShift && !strb.doLoad) |=> (remReg[0] == ($past(dataBit) ^ $past(fbBit))));
endmodule

// File: rtl/prog_crc_core.sv
module prog_crc_core
  import crc_eng_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  lenCode,
  input  logic [15:0] tapMask,
  input  logic        engineRun,
  input  logic        shiftEn,
  input  logic        dataBit,
  input  logic        seedWr,
  input  logic [15:0] seedVal,
  output logic [15:0] crcOut
);
  crcStrobes_t strb;

  crc_ctrl u_ctrl (
    .engineRun (engineRun),
    .shiftEn   (shiftEn),
    .seedWr    (seedWr),
    .strb      (strb)
  );

  crc_datapath #(.MAX_W(16)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .lenCode (lenCode),
    .tapMask (tapMask),
    .dataBit (dataBit),
    .seedVal (seedVal),
    .crcOut  (crcOut)
  );

  // R2: nothing visible above the programmed length
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (((crcOut >> lenCode) >> 1) == 16'h0000));

  // R8: running without a strobe keeps the result, seed requests or not
  p_run_blocks_seed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (engineRun && !shiftEn) |=> ((crcOut == $past(crcOut)) || (lenCode != $past(lenCode))));
endmodule

// File: tb/prog_crc_core_tb.sv
module prog_crc_core_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  lenCode = 4'hF;
  logic [15:0] tapMask = 16'h0;
  logic        engineRun = 0;
  logic        shiftEn = 0;
  logic        dataBit = 0;
  logic        seedWr = 0;
  logic [15:0] seedVal = 16'h0;
  logic [15:0] crcOut;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int model = 0;

  always #4 clk = ~clk;

  prog_crc_core u_dut (
    .clk(clk), .rst_n(rst_n), .lenCode(lenCode), .tapMask(tapMask),
    .engineRun(engineRun), .shiftEn(shiftEn), .dataBit(dataBit),
    .seedWr(seedWr), .seedVal(seedVal), .crcOut(crcOut)
  );

  function automatic int maskOf(int code);
    return (1 << (code + 1)) - 1;
  endfunction

  // behavioural reference: one accepted step per call
  function automatic int stepRef(int rem, int code, int taps, int d);
    int len = code + 1;
    int top = (rem >> (len - 1)) & 1;
    int nxt = ((rem << 1) | d) & maskOf(code);
    if (top != 0) nxt = nxt ^ ((taps | 1) & maskOf(code));
    return nxt;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) model = 0;
    else if (seedWr && !engineRun) model = int'(seedVal) & maskOf(int'(lenCode));
    else if (shiftEn && engineRun) model = stepRef(model, int'(lenCode), int'(tapMask), int'(dataBit));
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one cycle: compare against the model, then drive the next inputs
  task automatic cyc(bit sh, bit d, bit wr, logic [15:0] sv);
    @(negedge clk);
    check("R4 per-cycle model", int'(crcOut), model & maskOf(int'(lenCode)));
    shiftEn = sh; dataBit = d; seedWr = wr; seedVal = sv;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 16'h0);
  endtask

  task automatic seed(logic [15:0] v);
    engineRun = 0;
    cyc(0, 0, 1, v);
    idle();
  endtask

  task automatic feedByte(logic [7:0] b, bit gaps);
    for (int i = 7; i >= 0; i--) begin
      cyc(1, b[i], 0, 16'h0);
      if (gaps) idle();
    end
  endtask

  task automatic runMsg(bit gaps);
    string s = "123456789";
    engineRun = 1;
    for (int k = 0; k < 9; k++) feedByte(s[k], gaps);
    feedByte(8'h00, gaps);
    feedByte(8'h00, gaps);
    idle();
    idle();
  endtask

  initial begin
    int ra, rb, par;
    repeat (3) @(negedge clk);
    @(negedge clk);
    check("R1 reset value", int'(crcOut), 0);
    rst_n = 1;
    idle();

    // R9 / R4: 16-bit generator, known remainder
    lenCode = 4'hF; tapMask = 16'h1020;
    seed(16'h0);
    runMsg(0);
    check("R9 check string remainder", int'(crcOut), 16'h31C3);

    // R5 + R10: tap bit 0 set, idle gaps between strobes
    tapMask = 16'h1021;
    seed(16'h0);
    runMsg(1);
    check("R5 R10 tap bit0 and gaps", int'(crcOut), 16'h31C3);

    // R6: 8-bit generator, taps above the length ignored
    lenCode = 4'h7; tapMask = 16'h0031;
    seed(16'h0);
    engineRun = 1;
    feedByte(8'hA5, 0); feedByte(8'h3C, 0); feedByte(8'h00, 0);
    idle(); idle();
    ra = int'(crcOut);
    tapMask = 16'hFF31;
    seed(16'h0);
    engineRun = 1;
    feedByte(8'hA5, 0); feedByte(8'h3C, 0); feedByte(8'h00, 0);
    idle(); idle();
    rb = int'(crcOut);
    check("R6 high taps ignored", rb, ra);
    check("R2 upper bits zero len8", int'(crcOut) & 16'hFF00, 0);

    // R7: seed truncated to the length
    seed(16'hABCD);
    check("R7 seed truncated", int'(crcOut), 16'h00CD);

    // R8: seed while running, alone and together with a shift
    engineRun = 1;
    cyc(0, 0, 1, 16'h1234);
    idle();
    check("R8 seed ignored while running", int'(crcOut), 16'h00CD);
    cyc(1, 1, 1, 16'h5555);
    idle();
    check("R8 shift wins over seed", int'(crcOut), stepRef(16'hCD, 7, 16'h31, 1));

    // R3: strobe with engine stopped does nothing
    engineRun = 0;
    ra = int'(crcOut);
    cyc(1, 1, 0, 16'h0);
    idle();
    check("R3 no shift when stopped", int'(crcOut), ra);

    // R2 / R4: 1-bit generator is running parity
    lenCode = 4'h0; tapMask = 16'hFFFF;
    seed(16'h0);
    engineRun = 1;
    par = 0;
    for (int k = 0; k < 11; k++) begin
      cyc(1, (k % 3) == 0, 0, 16'h0);
      par ^= ((k % 3) == 0);
    end
    idle(); idle();
    check("R2 R4 one-bit parity", int'(crcOut), par);

    // R2: 5-bit generator, mixed data, upper bits stay zero
    lenCode = 4'h4; tapMask = 16'h0005;
    seed(16'h001F);
    engineRun = 1;
    feedByte(8'h9E, 0); feedByte(8'h61, 1);
    idle(); idle();
    check("R2 upper bits zero len5", int'(crcOut) & 16'hFFE0, 0);

    engineRun = 0;
    idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule